// File: doc/BRIEF.md
# Model-Backed PUF Authentication Session Controller

This block sequences one authentication exchange on the verifier side. On a `start` pulse it issues a run of 32-bit challenges, one at a time, taken from an internal maximal-length shift register. Each challenge goes out with a single-cycle `challenge_valid` strobe. That strobe is seen by the remote prover and by a local model of the prover's physical function, which computes its own prediction on demand. The controller collects the prover's 1-bit answer and the model's 1-bit prediction in any order and with any delay. Once both are present, it counts a mismatch if they differ and moves to the next challenge.

When the mismatch total (the Hamming distance) passes the tolerance `EPS`, the session stops at once and reports rejection. If all `N` challenges complete within tolerance, the session reports acceptance. The shift-register state is never returned to its seed between sessions, so no challenge repeats across authentications. Software can still plant a fresh seed while the controller is idle.

The controller is a five-state machine:
- `ST_IDLE`: waits for `start`. Leaving on `start` is transition T1 (to `ST_ISSUE`).
- `ST_ISSUE`: raises `challenge_valid` for one cycle. Transition T2 always follows (to `ST_WAIT`).
- `ST_WAIT`: latches each response as it arrives. When both are held, transition T3 (to `ST_CHECK`) compares them and steps the shift register.
- `ST_CHECK`: takes transition T4 (to `ST_FINISH`) when the count exceeds `EPS` or the last challenge is done. Otherwise it takes transition T5 (back to `ST_ISSUE`).
- `ST_FINISH`: raises `done` for one cycle. Transition T6 returns to `ST_IDLE`.

Top module: `puf_auth_verifier`

## Requirements
- R1: After reset, `challenge_valid`, `done`, `accept`, `reject` and `hamming_dist` are 0. The shift register holds `DEFAULT_SEED` (default 32'h0000_0001), so a session started without any seed load issues `DEFAULT_SEED` as its first challenge.
- R2: The challenge sequence follows x^32+x^31+x^30+x^10+1. The next state is `{s[30:0], s[31]^s[30]^s[29]^s[9]}`. A nonzero seed loaded while idle is the next challenge issued.
- R3: A seed load of zero stores `DEFAULT_SEED` instead, so the register never holds zero.
- R4: `seed_load` has effect only in `ST_IDLE`. A load during a session leaves the challenge sequence unchanged.
- R5: `challenge_valid` is a one-cycle pulse. The first pulse comes the cycle after `start` is sampled, and each later pulse comes only after both responses to the previous challenge have been taken.
- R6: `prover_valid` and `model_valid` may arrive in the same cycle or in either order, with delays. A challenge is compared only once both have been seen.
- R7: `hamming_dist` is cleared at `start` and rises by one for each challenge whose `prover_resp` differs from `model_resp`.
- R8: As soon as `hamming_dist` exceeds `EPS` (default 6), no further challenge is issued, and the session ends with `done` and `reject`.
- R9: After `N` (default 64) challenges with `hamming_dist` ≤ `EPS`, the session ends with `done` and `accept`. `done` lasts one cycle, exactly one flag is high with it, and the flags stay until the next `start`.
- R10: The shift register advances exactly once per compared challenge and keeps its state from one session to the next.
- R11: A `start` pulse during a session is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a session (used only when idle) |
| seed_load | input | 1 | Load `seed_value` into the shift register (used only when idle) |
| seed_value | input | 32 | Seed to load; zero is replaced by `DEFAULT_SEED` |
| prover_resp | input | 1 | Prover's answer bit |
| prover_valid | input | 1 | `prover_resp` is valid this cycle |
| model_resp | input | 1 | Local model's predicted bit |
| model_valid | input | 1 | `model_resp` is valid this cycle |
| challenge | output | 32 | Current challenge |
| challenge_valid | output | 1 | One-cycle request to prover and model |
| done | output | 1 | One-cycle end-of-session pulse |
| accept | output | 1 | Session passed |
| reject | output | 1 | Session failed |
| hamming_dist | output | $clog2(N+1) | Mismatches counted in this session |

## Verification
A shift register stepped at the wrong moment, or loaded while busy, shows on the very next `challenge_valid` as a challenge value that differs from the polynomial sequence the bench computes. The bench checks every challenge, so such an error is caught within one challenge period, including across session boundaries. A wrong mismatch count or a wrong threshold decision shows at `done`. It appears either as a challenge count that differs from the first index at which the expected count passes `EPS`, or as the wrong flag. The bench drives patterns that sit exactly at `EPS` and one above it, so an off-by-one in the threshold compare changes the outcome of a whole session.

// File: rtl/puf_auth_pkg.sv
package puf_auth_pkg;

    localparam int CHAL_W = 32;

    // taps for x^32 + x^31 + x^30 + x^10 + 1 : state bits 31, 30, 29, 9
    localparam logic [CHAL_W-1:0] TAP_MASK = 32'hE000_0200;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_CHECK,
        ST_FINISH
    } vstate_t;

    function automatic logic [CHAL_W-1:0] lfsr_step(input logic [CHAL_W-1:0] s);
        return {s[CHAL_W-2:0], ^(s & TAP_MASK)};
    endfunction

endpackage

// File: rtl/chal_lfsr.sv
module chal_lfsr
    import puf_auth_pkg::*;
#(
    parameter logic [CHAL_W-1:0] DEFAULT_SEED = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAL_W-1:0] load_val,
    input  logic              step,
    output logic [CHAL_W-1:0] state
);

    logic [CHAL_W-1:0] seed_fixed;

    always_comb begin
        seed_fixed = (load_val == '0) ? DEFAULT_SEED : load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DEFAULT_SEED;
        end else if (load) begin
            state <= seed_fixed;
        end else if (step) begin
            state <= lfsr_step(state);
        end
    end

    // R3: the register never reaches the lock-up value
    a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    // R10: without load or step the state holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> state == $past(state));

    // R2: a step applies the feedback polynomial
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> state == lfsr_step($past(state)));

endmodule

// File: rtl/hd_counter.sv
module hd_counter #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    // R7: the distance moves by at most one per cycle outside a clear
    a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/puf_auth_verifier.sv
module puf_auth_verifier
    import puf_auth_pkg::*;
#(
    parameter int                N            = 64,
    parameter int                EPS          = 6,
    parameter logic [CHAL_W-1:0] DEFAULT_SEED = 32'h0000_0001,
    localparam int               CW           = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              seed_load,
    input  logic [CHAL_W-1:0] seed_value,
    input  logic              prover_resp,
    input  logic              prover_valid,
    input  logic              model_resp,
    input  logic              model_valid,
    output logic [CHAL_W-1:0] challenge,
    output logic              challenge_valid,
    output logic              done,
    output logic              accept,
    output logic              reject,
    output logic [CW-1:0]     hamming_dist
);

    localparam logic [31:0]   EPS_V = 32'(EPS);
    localparam logic [CW-1:0] N_V   = CW'(N);

    vstate_t       state_q, state_d;
    logic [CW-1:0] idx_q;
    logic          p_got_q, m_got_q, p_bit_q, m_bit_q;
    logic          accept_q, reject_q;

    logic          both_ready, p_now, m_now, compare_fire, mismatch;
    logic          exceed, last_done, sess_clr, lfsr_load;

    // ---------------- datapath pieces ----------------
    assign sess_clr  = (state_q == ST_IDLE) && start;
    assign lfsr_load = (state_q == ST_IDLE) && seed_load;

    always_comb begin
        p_now        = p_got_q ? p_bit_q : prover_resp;
        m_now        = m_got_q ? m_bit_q : model_resp;
        both_ready   = (p_got_q || prover_valid) && (m_got_q || model_valid);
        compare_fire = (state_q == ST_WAIT) && both_ready;
        mismatch     = p_now ^ m_now;
        exceed       = 32'(hamming_dist) > EPS_V;
        last_done    = idx_q == N_V;
    end

    chal_lfsr #(.DEFAULT_SEED(DEFAULT_SEED)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lfsr_load),
        .load_val (seed_value),
        .step     (compare_fire),
        .state    (challenge)
    );

    hd_counter #(.CW(CW)) u_hd (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sess_clr),
        .inc   (compare_fire && mismatch),
        .count (hamming_dist)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (both_ready) state_d = ST_CHECK;
            ST_CHECK:  state_d = (exceed || last_done) ? ST_FINISH : ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- per-session registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            p_got_q  <= 1'b0;
            m_got_q  <= 1'b0;
            p_bit_q  <= 1'b0;
            m_bit_q  <= 1'b0;
            accept_q <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            if (sess_clr) begin
                idx_q    <= '0;
                accept_q <= 1'b0;
                reject_q <= 1'b0;
            end
            if (state_q == ST_ISSUE) begin
                p_got_q <= 1'b0;
                m_got_q <= 1'b0;
            end
            if (state_q == ST_WAIT) begin
                if (prover_valid && !p_got_q) begin
                    p_got_q <= 1'b1;
                    p_bit_q <= prover_resp;
                end
                if (model_valid && !m_got_q) begin
                    m_got_q <= 1'b1;
                    m_bit_q <= model_resp;
                end
            end
            if (compare_fire) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_CHECK && (exceed || last_done)) begin
                accept_q <= !exceed;
                reject_q <= exceed;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        challenge_valid = 1'b0;
        done            = 1'b0;
        unique case (state_q)
            ST_ISSUE:  challenge_valid = 1'b1;
            ST_FINISH: done            = 1'b1;
            default:   ;
        endcase
        accept = accept_q;
        reject = reject_q;
    end

    // ---------------- assertions ----------------
    a_r5_cv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        challenge_valid |=> !challenge_valid);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (accept ^ reject));

    a_r8_no_issue_past_eps: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(hamming_dist) > EPS_V) |-> !challenge_valid);

    a_r9_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !(state_q == ST_IDLE && start)) |=> $stable({accept, reject}) || done);

    a_r6_wait_until_both: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !both_ready) |=> $stable(challenge));

endmodule

// File: tb/puf_auth_verifier_test.sv
module puf_auth_verifier_test;

    localparam int N   = 64;
    localparam int EPS = 6;
    localparam int CW  = $clog2(N + 1);
    localparam logic [31:0] DSEED = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic        prover_resp = 1'b0, prover_valid = 1'b0;
    logic        model_resp = 1'b0, model_valid = 1'b0;
    logic [31:0] challenge;
    logic        challenge_valid, done, accept, reject;
    logic [CW-1:0] hamming_dist;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_lfsr = DSEED;

    always #2 clk = ~clk;

    puf_auth_verifier uut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load),
        .seed_value(seed_value), .prover_resp(prover_resp), .prover_valid(prover_valid),
        .model_resp(model_resp), .model_valid(model_valid), .challenge(challenge),
        .challenge_valid(challenge_valid), .done(done), .accept(accept),
        .reject(reject), .hamming_dist(hamming_dist)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[30] ^ s[29] ^ s[9]};
    endfunction

    function automatic bit mis(input int mode, input int i);
        case (mode)
            1: return i < EPS;
            2: return i <= EPS;
            3: return (i % 9) == 0;
            4: return (i % 11) == 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_seed(input logic [31:0] v);
        @(negedge clk); seed_load = 1'b1; seed_value = v;
        @(negedge clk); seed_load = 1'b0;
        exp_lfsr = (v == 0) ? DSEED : v;
    endtask

    task automatic session(input int mode, input bit inject);
        int cnt = 0, issued = 0, exp_issued = N, exp_cnt = 0;
        bit fin = 0;
        for (int k = 0; k < N; k++) begin
            exp_cnt += int'(mis(mode, k));
            if (exp_cnt > EPS) begin exp_issued = k + 1; break; end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int g = 0; g < 4000 && !fin; g++) begin
            if (done) begin
                chk("R8/R9 challenges issued", 64'(issued), 64'(exp_issued));
                chk("R7 hamming_dist", 64'(hamming_dist), 64'(exp_cnt));
                chk("R8/R9 accept", 64'(accept), 64'(exp_cnt <= EPS));
                chk("R8/R9 reject", 64'(reject), 64'(exp_cnt > EPS));
                @(negedge clk);
                chk("R9 done pulse", 64'(done), 64'd0);
                chk("R9 flags held", 64'({accept, reject}), exp_cnt > EPS ? 64'd1 : 64'd2);
                fin = 1;
            end else if (challenge_valid) begin
                int dp = issued % 3;
                int dm = (issued + mode) % 3;
                int mx = (dp > dm) ? dp : dm;
                logic mb = ^challenge;
                chk(issued == 0 ? "R1/R2/R3 first challenge" : "R2/R10 challenge",
                    64'(challenge), 64'(exp_lfsr));
                if (cnt > EPS) chk("R8 challenge after exceed", 64'd1, 64'd0);
                @(negedge clk);
                chk("R5 challenge_valid one cycle", 64'(challenge_valid), 64'd0);
                for (int c = 0; c <= mx; c++) begin
                    prover_valid = (c == dp);
                    model_valid  = (c == dm);
                    prover_resp  = (c == dp) ? (mb ^ mis(mode, issued)) : ~mb;
                    model_resp   = (c == dm) ? mb : ~mb;
                    if (inject && issued == 3 && c == 0) begin
                        seed_load = 1'b1; seed_value = 32'hDEAD_BEEF; start = 1'b1;
                    end else begin
                        seed_load = 1'b0; start = 1'b0;
                    end
                    if (c < mx) begin
                        @(negedge clk);
                        chk("R6 no new challenge before both", 64'(challenge_valid), 64'd0);
                    end
                end
                @(negedge clk);
                prover_valid = 1'b0; model_valid = 1'b0;
                seed_load = 1'b0; start = 1'b0;
                cnt += int'(mis(mode, issued));
                exp_lfsr = nxt(exp_lfsr);
                issued++;
            end
            if (!fin) @(negedge clk);
        end
        if (!fin) chk("R9 session completes", 64'd0, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset challenge_valid", 64'(challenge_valid), 64'd0);
        chk("R1 reset done", 64'(done), 64'd0);
        chk("R1 reset flags", 64'({accept, reject}), 64'd0);
        chk("R1 reset hamming_dist", 64'(hamming_dist), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'(challenge_valid | done), 64'd0);
        session(0, 1'b0);             // R1 default seed, R9 accept at zero distance
        session(2, 1'b0);             // R10 carry-forward, R8 reject at EPS+1
        load_seed(32'h0000_0000);     // R3 zero seed
        session(1, 1'b1);             // R9 accept at exactly EPS, R4/R11 ignored mid-session
        session(3, 1'b0);             // R4 carry-forward after ignored load, R8 late reject
        load_seed(32'hACE1_2345);     // R2 nonzero seed
        session(4, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule